// File: doc/BRIEF.md
# Dynamic Scenario Handle Port

This block is the parallel entry point a waveform sequencer uses when scenarios are picked in real time by outside logic instead of by its own stored handle table. An external source presents a 16-bit handle together with a valid strobe. On a later trigger event the block turns the most recent accepted handle into a one-cycle jump request for the sequencer.

Each presented handle is checked against the number of scenarios currently loaded. A handle that does not name a loaded scenario is dropped, and a flag records that this happened. When dynamic selection is switched off, the block passes the sequencer's internal handle path straight through, with one register of delay, and discards anything held from the external side. The trigger edge (rising or falling) and the sizes are parameters.

Top module: `scn_handle_port`

## Requirements
- R1: After reset `jump_req_o`, `jump_handle_o` and `oor_flag_o` are all 0.
- R2: With `dyn_mode_i` high, a clock edge where `ext_valid_i` is 1 and `ext_chsel_i` is 0 captures `ext_data_i` as the pending handle if its value is below the limit. The limit is `scn_count_i`, clamped to `MAX_SCN`.
- R3: A trigger event is an edge at which `ext_trig_i` is at its active level (high for the default rising setting) after being inactive at the previous edge. With `dyn_mode_i` high and a handle pending, a trigger event drives `jump_req_o` to 1 for exactly the following cycle, with `jump_handle_o` equal to that handle, and consumes the handle. A trigger held active gives only one event.
- R4: A trigger event with no handle pending produces no jump request.
- R5: A newer accepted handle replaces a pending handle that has not yet been used.
- R6: When a valid handle and a trigger event come at the same edge, the jump uses the handle pending before that edge, and the new handle becomes pending.
- R7: A handle at or above the limit is rejected and leaves the pending handle unchanged. It sets `oor_flag_o` in the next cycle. The flag stays set until reset.
- R8: A strobe taken while `ext_chsel_i` is 1 is ignored: nothing becomes pending and the flag is not set.
- R9: With `dyn_mode_i` low, the external inputs are ignored and any pending handle is discarded. `jump_req_o` and `jump_handle_o` follow `int_jump_req_i` and `int_handle_i` one cycle later.
- R10: `jump_handle_o` holds its last value between jump requests.
- R11: If `scn_count_i` exceeds `MAX_SCN`, handles up to `MAX_SCN-1` are accepted and `MAX_SCN` is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock; all capture happens on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dyn_mode_i | input | 1 | 1 selects the external handle source, 0 the internal path |
| scn_count_i | input | CW (14) | Number of loaded scenarios |
| ext_data_i | input | DATA_W (16) | External scenario handle |
| ext_valid_i | input | 1 | Strobe qualifying `ext_data_i` |
| ext_trig_i | input | 1 | External trigger line |
| ext_chsel_i | input | 1 | Reserved select line; must be held low |
| int_jump_req_i | input | 1 | Jump request from the internal handle path |
| int_handle_i | input | HW (13) | Handle from the internal handle path |
| jump_req_o | output | 1 | One-cycle jump request to the sequencer |
| jump_handle_o | output | HW (13) | Handle accompanying the jump request |
| oor_flag_o | output | 1 | Sticky flag for a rejected out-of-range handle |

## Verification
The properties assume that `scn_count_i` does not change while a handle is waiting and that the internal path's handle is itself below `MAX_SCN`. The stimulus sets the count only while nothing is pending and keeps internal handles small. The no-back-to-back pulse property relies on the trigger being sampled only at the sync clock, so the stimulus changes every input only on the falling clock edge and holds it for whole cycles.

// File: rtl/scn_port_pkg.sv
package scn_port_pkg;

   typedef enum logic {
      TRIG_RISE = 1'b0,
      TRIG_FALL = 1'b1
   } trig_edge_e;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/scn_trig_detect.sv
module scn_trig_detect
   import scn_port_pkg::*;
#(
   parameter trig_edge_e EDGE = TRIG_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   output logic event_o
);

   logic act;
   logic prev_act;

   generate
      if (EDGE == TRIG_FALL) begin : g_fall
         assign act = ~trig_i;
      end else begin : g_rise
         assign act = trig_i;
      end
   endgenerate

   // Starts as "already active" so a line resting at its active level
   // out of reset does not count as an event.
   always_ff @(posedge clk) begin
      if (!rst_n) prev_act <= 1'b1;
      else        prev_act <= act;
   end

   assign event_o = act & ~prev_act;

endmodule

// File: rtl/scn_handle_capture.sv
module scn_handle_capture #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned MAX_SCN = 8192,
   parameter int unsigned HW      = 13,
   parameter int unsigned CW      = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              valid_i,
   input  logic              chsel_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CW-1:0]     count_i,
   input  logic              take_i,
   output logic              fire_o,
   output logic [HW-1:0]     handle_o,
   output logic              oor_o
);

   localparam int unsigned CMP_W = (DATA_W > CW) ? DATA_W : CW;
   localparam logic [CW-1:0] MAX_C = CW'(MAX_SCN);

   logic [CW-1:0] limit;
   logic          in_range;
   logic          strobe;
   logic          pend_vld;
   logic [HW-1:0] pend_h;
   logic          oor_q;

   assign limit    = (count_i > MAX_C) ? MAX_C : count_i;
   assign in_range = CMP_W'(data_i) < CMP_W'(limit);
   assign strobe   = enable_i & valid_i & ~chsel_i;
   assign fire_o   = enable_i & take_i & pend_vld;
   assign handle_o = pend_h;
   assign oor_o    = oor_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_vld <= 1'b0;
         pend_h   <= '0;
      end else if (!enable_i) begin
         pend_vld <= 1'b0;
      end else begin
         if (take_i) pend_vld <= 1'b0;
         if (strobe && in_range) begin
            pend_vld <= 1'b1;
            pend_h   <= data_i[HW-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   oor_q <= 1'b0;
      else if (strobe && !in_range) oor_q <= 1'b1;
   end

endmodule

// File: rtl/scn_jump_mux.sv
module scn_jump_mux #(
   parameter int unsigned HW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_ext_i,
   input  logic          ext_fire_i,
   input  logic [HW-1:0] ext_handle_i,
   input  logic          int_req_i,
   input  logic [HW-1:0] int_handle_i,
   output logic          req_o,
   output logic [HW-1:0] handle_o
);

   logic          nxt_req;
   logic [HW-1:0] nxt_handle;

   always_comb begin
      if (sel_ext_i) begin
         nxt_req    = ext_fire_i;
         nxt_handle = ext_handle_i;
      end else begin
         nxt_req    = int_req_i;
         nxt_handle = int_handle_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_o    <= 1'b0;
         handle_o <= '0;
      end else begin
         req_o <= nxt_req;
         if (nxt_req) handle_o <= nxt_handle;
      end
   end

endmodule

// File: rtl/scn_handle_port.sv
module scn_handle_port
   import scn_port_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned MAX_SCN   = 8192,
   parameter trig_edge_e  TRIG_EDGE = TRIG_RISE,
   localparam int unsigned HW       = bits_for(MAX_SCN),
   localparam int unsigned CW       = bits_for(MAX_SCN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dyn_mode_i,
   input  logic [CW-1:0]     scn_count_i,
   input  logic [DATA_W-1:0] ext_data_i,
   input  logic              ext_valid_i,
   input  logic              ext_trig_i,
   input  logic              ext_chsel_i,
   input  logic              int_jump_req_i,
   input  logic [HW-1:0]     int_handle_i,
   output logic              jump_req_o,
   output logic [HW-1:0]     jump_handle_o,
   output logic              oor_flag_o
);

   generate
      if (MAX_SCN < 2) begin : g_bad_count
         $error("MAX_SCN must be at least 2");
      end
      if (HW > DATA_W) begin : g_bad_width
         $error("handle bus too narrow for MAX_SCN");
      end
   endgenerate

   logic          trig_evt;
   logic          ext_fire;
   logic [HW-1:0] ext_handle;

   scn_trig_detect #(.EDGE(TRIG_EDGE)) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_i  (ext_trig_i),
      .event_o (trig_evt)
   );

   scn_handle_capture #(
      .DATA_W  (DATA_W),
      .MAX_SCN (MAX_SCN),
      .HW      (HW),
      .CW      (CW)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (dyn_mode_i),
      .valid_i  (ext_valid_i),
      .chsel_i  (ext_chsel_i),
      .data_i   (ext_data_i),
      .count_i  (scn_count_i),
      .take_i   (trig_evt),
      .fire_o   (ext_fire),
      .handle_o (ext_handle),
      .oor_o    (oor_flag_o)
   );

   scn_jump_mux #(.HW(HW)) u_mux (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_ext_i    (dyn_mode_i),
      .ext_fire_i   (ext_fire),
      .ext_handle_i (ext_handle),
      .int_req_i    (int_jump_req_i),
      .int_handle_i (int_handle_i),
      .req_o        (jump_req_o),
      .handle_o     (jump_handle_o)
   );

endmodule

// File: rtl/scn_handle_port_chk.sv
module scn_handle_port_chk #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned MAX_SCN = 8192,
   parameter int unsigned HW      = 13,
   parameter int unsigned CW      = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dyn_mode_i,
   input logic [CW-1:0]     scn_count_i,
   input logic [DATA_W-1:0] ext_data_i,
   input logic              ext_valid_i,
   input logic              ext_chsel_i,
   input logic              int_jump_req_i,
   input logic [HW-1:0]     int_handle_i,
   input logic              jump_req_o,
   input logic [HW-1:0]     jump_handle_o,
   input logic              oor_flag_o
);

   // R3
   one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dyn_mode_i && jump_req_o) |=> !jump_req_o);

   // R7
   oor_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oor_flag_o |=> oor_flag_o);

   // R7
   oor_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dyn_mode_i && ext_valid_i && !ext_chsel_i &&
       (32'(ext_data_i) >= 32'(scn_count_i))) |=> oor_flag_o);

   // R9
   int_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dyn_mode_i |=> (jump_req_o == $past(int_jump_req_i)));

   // R9
   int_handle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dyn_mode_i && int_jump_req_i) |=> (jump_handle_o == $past(int_handle_i)));

   // R2
   handle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_req_o && $past(dyn_mode_i)) |-> (32'(jump_handle_o) < MAX_SCN));

endmodule

bind scn_handle_port scn_handle_port_chk #(
   .DATA_W  (DATA_W),
   .MAX_SCN (MAX_SCN),
   .HW      (HW),
   .CW      (CW)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .dyn_mode_i     (dyn_mode_i),
   .scn_count_i    (scn_count_i),
   .ext_data_i     (ext_data_i),
   .ext_valid_i    (ext_valid_i),
   .ext_chsel_i    (ext_chsel_i),
   .int_jump_req_i (int_jump_req_i),
   .int_handle_i   (int_handle_i),
   .jump_req_o     (jump_req_o),
   .jump_handle_o  (jump_handle_o),
   .oor_flag_o     (oor_flag_o)
);

// File: tb/scn_handle_port_bench.sv
`timescale 1ns/1ps
module scn_handle_port_bench;

   localparam int DATA_W  = 16;
   localparam int MAX_SCN = 8192;
   localparam int HW      = 13;
   localparam int CW      = 14;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              dyn_mode_i = 1'b1;
   logic [CW-1:0]     scn_count_i = CW'(100);
   logic [DATA_W-1:0] ext_data_i = '0;
   logic              ext_valid_i = 1'b0;
   logic              ext_trig_i = 1'b0;
   logic              ext_chsel_i = 1'b0;
   logic              int_jump_req_i = 1'b0;
   logic [HW-1:0]     int_handle_i = '0;
   logic              jump_req_o;
   logic [HW-1:0]     jump_handle_o;
   logic              oor_flag_o;

   always #4 clk = ~clk;

   scn_handle_port u_scn_handle_port (
      .clk            (clk),
      .rst_n          (rst_n),
      .dyn_mode_i     (dyn_mode_i),
      .scn_count_i    (scn_count_i),
      .ext_data_i     (ext_data_i),
      .ext_valid_i    (ext_valid_i),
      .ext_trig_i     (ext_trig_i),
      .ext_chsel_i    (ext_chsel_i),
      .int_jump_req_i (int_jump_req_i),
      .int_handle_i   (int_handle_i),
      .jump_req_o     (jump_req_o),
      .jump_handle_o  (jump_handle_o),
      .oor_flag_o     (oor_flag_o)
   );

   int checks = 0;
   int fails  = 0;
   int exp_q[$];
   int pushed = 0;
   int seen   = 0;
   bit m_vld  = 0;
   int m_pend = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every jump pulse (R3, R9)
   always @(negedge clk) begin
      if (rst_n && jump_req_o) begin
         seen++;
         if (exp_q.size() == 0) chk(0, "R4 unexpected jump", int'(jump_handle_o), -1);
         else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(jump_handle_o) == e, "R3 jump handle", int'(jump_handle_o), e);
         end
      end
   end

   function automatic int lim();
      return (int'(scn_count_i) > MAX_SCN) ? MAX_SCN : int'(scn_count_i);
   endfunction

   task automatic put(input int d, input bit cs = 0);
      ext_valid_i = 1; ext_data_i = DATA_W'(d); ext_chsel_i = cs;
      if (dyn_mode_i && !cs && d < lim()) begin m_vld = 1; m_pend = d; end
      @(negedge clk);
      ext_valid_i = 0; ext_chsel_i = 0;
   endtask

   task automatic fire();
      ext_trig_i = 1;
      if (dyn_mode_i && m_vld) begin exp_q.push_back(m_pend); pushed++; m_vld = 0; end
      @(negedge clk);
      ext_trig_i = 0;
   endtask

   task automatic put_fire(input int d);
      ext_valid_i = 1; ext_data_i = DATA_W'(d); ext_trig_i = 1;
      if (m_vld) begin exp_q.push_back(m_pend); pushed++; m_vld = 0; end
      if (d < lim()) begin m_vld = 1; m_pend = d; end
      @(negedge clk);
      ext_valid_i = 0; ext_trig_i = 0;
   endtask

   task automatic int_jump(input int h);
      int_jump_req_i = 1; int_handle_i = HW'(h);
      exp_q.push_back(h); pushed++;
      @(negedge clk);
      int_jump_req_i = 0;
   endtask

   task automatic settle(input string req);
      repeat (2) @(negedge clk);
      chk(seen == pushed, req, seen, pushed);
   endtask

   task automatic do_reset();
      rst_n = 0; m_vld = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk(jump_req_o == 0, "R1 req", int'(jump_req_o), 0);
      chk(jump_handle_o == 0, "R1 handle", int'(jump_handle_o), 0);
      chk(oor_flag_o == 0, "R1 oor", int'(oor_flag_o), 0);

      // R2 R3 capture then trigger
      put(5); fire(); settle("R3 count");
      // R10 handle holds
      repeat (3) @(negedge clk);
      chk(jump_handle_o == 5, "R10 hold", int'(jump_handle_o), 5);
      // R4 trigger with nothing pending
      fire(); settle("R4 count");
      // R5 replacement
      put(7); put(9); fire(); settle("R5 count");
      // R6 simultaneous strobe and trigger
      put(11); put_fire(12); settle("R6 first");
      fire(); settle("R6 second");
      // R3 held trigger gives one event
      put(20);
      ext_trig_i = 1; exp_q.push_back(20); pushed++; m_vld = 0;
      repeat (3) @(negedge clk);
      put(21);
      settle("R3 held");
      ext_trig_i = 0; @(negedge clk);
      fire(); settle("R3 rearm");
      // R2 boundary count-1
      put(99); fire(); settle("R2 boundary");
      chk(oor_flag_o == 0, "R2 no flag", int'(oor_flag_o), 0);
      // R8 reserved select high
      put(3, 1); put(500, 1); fire(); settle("R8 ignored");
      chk(oor_flag_o == 0, "R8 no flag", int'(oor_flag_o), 0);
      // R9 internal path, external ignored, pending dropped
      put(30);
      dyn_mode_i = 0; m_vld = 0;
      int_jump(42); settle("R9 internal");
      put(44); fire(); settle("R9 ext ignored");
      dyn_mode_i = 1; @(negedge clk);
      fire(); settle("R9 pending dropped");
      // R7 out of range rejected, pending kept, sticky
      put(50); put(100);
      chk(oor_flag_o == 1, "R7 flag set", int'(oor_flag_o), 1);
      fire(); settle("R7 pending kept");
      put(1);
      chk(oor_flag_o == 1, "R7 sticky", int'(oor_flag_o), 1);
      fire(); settle("R7 after");
      do_reset();
      chk(oor_flag_o == 0, "R1 oor cleared", int'(oor_flag_o), 0);
      // R11 count above MAX_SCN clamps
      scn_count_i = CW'(9000); @(negedge clk);
      put(8191); fire(); settle("R11 top accepted");
      chk(oor_flag_o == 0, "R11 no flag", int'(oor_flag_o), 0);
      put(8192);
      chk(oor_flag_o == 1, "R11 clamp reject", int'(oor_flag_o), 1);
      fire(); settle("R11 no jump");

      chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule